// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and offers the highest-priority one to a processor through a single interrupt output. Requests are latched into a request register. Requests that are enabled are compared against the levels already being serviced. An acknowledge moves the winning request into the in-service register and presents an eight-bit vector. The vector is built from a programmed base and the winning level.

Software reaches the controller through a byte-wide register bus that has a one-bit address. Address 0 is the control port. Address 1 is the data port. A control write with bit 4 set starts an initialization sequence. The sequence consumes the vector base, the cascade word and, when requested, a mode word, all on the data port. After that, data-port writes load the mask. Control-port writes without bit 4 act as end-of-interrupt commands or as read-select and poll commands.

A separate trigger register chooses edge or level sensing for each input. It is loaded from the write-data bus by its own strobe. The cascade word is only stored and presented on an output.

Top module: `prio_intc`

## Requirements
- R1: After reset, intOut is 0 and vecOut is 0x00. The mask is 0xFF, and a data-port read returns it. A control-port read returns the request register, which is 0x00. Every input is edge-sensed.
- R2: A control-port write with bit 4 set (ICW1) does the following: it clears the in-service register and the mask to 0x00, selects the request register for control reads, cancels a pending poll and starts the initialization sequence. Bit 0 of that write requests a mode word. Bit 3 set makes every input level-sensed until the next ICW1.
- R3: After ICW1 the data-port writes have these meanings, in order. The first is the vector base, of which bits 7:3 are kept. The second is the cascade word, which appears on cascCfg. The third is a mode word, which is consumed with no other effect and occurs only if ICW1 bit 0 was set. Data writes made during this sequence leave the mask unchanged.
- R4: Once the sequence ends, each data-port write loads the mask. A mask bit of 1 blocks that input from the priority decision, but the input is still recorded in the request register.
- R5: On an edge-sensed input, a 0-to-1 transition sets the request bit one clock later. The bit stays set after the input falls and clears only when that level is acknowledged.
- R6: trigWr loads the trigger register from wrData, where a bit of 1 makes that input level-sensed. A level-sensed request bit copies the input every clock.
- R7: Level 0 has the highest priority and level 7 the lowest. intOut is 1 exactly when the lowest-numbered unmasked request is numbered below every set in-service bit, or when no in-service bit is set.
- R8: An intAck pulse while intOut is 1 sets the winner's in-service bit and clears its request bit. From the next clock, vecOut shows {base[7:3], level}. vecOut holds its value until the next intAck.
- R9: An intAck pulse while intOut is 0 leaves the in-service register unchanged and sets vecOut to {base[7:3], 3'b111}.
- R10: A control-port write of 0x20 (bits 4 and 3 clear, OCW2) clears the lowest-numbered set in-service bit. Any other value written with bits 4 and 3 clear has no effect.
- R11: A control-port write with bit 4 clear and bit 3 set is OCW3. In it, bits 1:0 = 11 select the in-service register for later control reads, bits 1:0 = 10 select the request register, and other values leave the selection unchanged.
- R12: OCW3 with bit 2 set arms a poll. The next control-port read returns {pending, 4'b0000, level}, where pending equals intOut, and returns 0x00 when intOut is 0. That read acts as an acknowledge without changing vecOut. Later reads follow the R11 selection again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Register address: 0 control, 1 data |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, valid while rdEn is high |
| trigWr | input | 1 | Loads the trigger register from wrData |
| irqIn | input | 8 | Interrupt request inputs |
| intOut | output | 1 | Interrupt to the processor |
| intAck | input | 1 | Acknowledge pulse |
| vecOut | output | 8 | Vector of the last acknowledge |
| cascCfg | output | 8 | Stored cascade word |

## Verification
The directed part programs two sequences, one with a mode word and one without, so the data-port write that becomes the mask is tested for both lengths. It then raises requests one at a time: a masked one shows in the request register but raises no interrupt, and a lower-numbered one preempts a level already in service while a higher-numbered one does not. End-of-interrupt, ignored OCW2 values, a spurious acknowledge, a held level input and a poll read each follow at a point where the in-service register contents make their effect unambiguous. The random part toggles inputs and mixes acknowledges, reads, masks, trigger changes and the occasional restart of initialization, which tests the priority decision against many combinations of in-service and request bits.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int NUM_IN = 8;
  parameter int DATA_W = 8;
  localparam int LVL_W = $clog2(NUM_IN);
  localparam int BASE_W = DATA_W - LVL_W;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_BASE = 2'd1,
    PH_CASC = 2'd2,
    PH_MODE = 2'd3
  } phase_t;

  // strobes and state from the control unit to the datapath
  typedef struct packed {
    logic icw1;
    logic ldBase;
    logic ldCasc;
    logic ldMask;
    logic ldTrig;
    logic eoi;
    logic pollRead;
    logic selIsr;
    logic pollArmed;
    logic ltim;
  } pic_cmd_t;

  typedef struct packed {
    logic             valid;
    logic [LVL_W-1:0] idx;
  } pick_t;

  function automatic pick_t pickLowest(logic [NUM_IN-1:0] v);
    pick_t p;
    p = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.valid = 1'b1;
        p.idx = LVL_W'(i);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              trigWr,
  output pic_cmd_t          cmd,
  output phase_t            phaseQ
);
  logic needMode;
  logic ltimQ;
  logic selIsrQ;
  logic pollQ;
  logic ctlWr, datWr, isIcw1, isOcw2, isOcw3, pollRd;

  always_comb begin
    ctlWr  = wrEn & ~addr;
    datWr  = wrEn & addr;
    isIcw1 = ctlWr & wrData[4];
    isOcw2 = ctlWr & ~wrData[4] & ~wrData[3];
    isOcw3 = ctlWr & ~wrData[4] & wrData[3];
    pollRd = rdEn & ~addr & pollQ;

    cmd.icw1      = isIcw1;
    cmd.ldBase    = datWr && (phaseQ == PH_BASE);
    cmd.ldCasc    = datWr && (phaseQ == PH_CASC);
    cmd.ldMask    = datWr && (phaseQ == PH_RUN);
    cmd.ldTrig    = trigWr;
    cmd.eoi       = isOcw2 && (wrData == DATA_W'(8'h20));
    cmd.pollRead  = pollRd;
    cmd.selIsr    = selIsrQ;
    cmd.pollArmed = pollQ;
    cmd.ltim      = ltimQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= PH_RUN;
      needMode <= 1'b0;
      ltimQ    <= 1'b0;
      selIsrQ  <= 1'b0;
      pollQ    <= 1'b0;
    end else if (isIcw1) begin
      phaseQ   <= PH_BASE;
      needMode <= wrData[0];
      ltimQ    <= wrData[3];
      selIsrQ  <= 1'b0;
      pollQ    <= 1'b0;
    end else begin
      if (datWr) begin
        case (phaseQ)
          PH_BASE: phaseQ <= PH_CASC;
          PH_CASC: phaseQ <= needMode ? PH_MODE : PH_RUN;
          PH_MODE: phaseQ <= PH_RUN;
          default: phaseQ <= PH_RUN;
        endcase
      end
      if (pollRd) pollQ <= 1'b0;
      if (isOcw3) begin
        if (wrData[1]) selIsrQ <= wrData[0];
        if (wrData[2]) pollQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_dpath.sv
module pic_dpath
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pic_cmd_t          cmd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              intAck,
  output logic              intOut,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] vecOut,
  output logic [DATA_W-1:0] cascCfg
);
  logic [NUM_IN-1:0] irr, isr, mask, trig, irqPrev;
  logic [NUM_IN-1:0] ackBit, eoiBit;
  logic [BASE_W-1:0] base;
  pick_t candPick, isrPick;
  logic ackNow;

  always_comb begin
    candPick = pickLowest(irr & ~mask);
    isrPick  = pickLowest(isr);
    intOut   = candPick.valid && (!isrPick.valid || (candPick.idx < isrPick.idx));
    ackNow   = (intAck | cmd.pollRead) & intOut;
    ackBit   = ackNow ? (NUM_IN'(1) << candPick.idx) : '0;
    eoiBit   = (cmd.eoi && isrPick.valid) ? (NUM_IN'(1) << isrPick.idx) : '0;
  end

  always_comb begin
    if (addr)
      rdData = DATA_W'(mask);
    else if (cmd.pollArmed)
      rdData = {intOut, {(DATA_W-1-LVL_W){1'b0}}, (intOut ? candPick.idx : {LVL_W{1'b0}})};
    else if (cmd.selIsr)
      rdData = DATA_W'(isr);
    else
      rdData = DATA_W'(irr);
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_req
    logic isLevel, rise, nextBit;
    always_comb begin
      isLevel = trig[g] | cmd.ltim;
      rise    = irqIn[g] & ~irqPrev[g];
      nextBit = (isLevel ? irqIn[g] : (irr[g] | rise)) & ~ackBit[g];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irr[g] <= 1'b0;
      else       irr[g] <= nextBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isr     <= '0;
      mask    <= '1;
      trig    <= '0;
      irqPrev <= '0;
      base    <= '0;
      cascCfg <= '0;
      vecOut  <= '0;
    end else begin
      irqPrev <= irqIn;
      if (cmd.icw1) isr <= '0;
      else          isr <= (isr & ~eoiBit) | ackBit;
      if (cmd.icw1)        mask <= '0;
      else if (cmd.ldMask) mask <= wrData[NUM_IN-1:0];
      if (cmd.ldTrig) trig <= wrData[NUM_IN-1:0];
      if (cmd.ldBase) base <= wrData[DATA_W-1:LVL_W];
      if (cmd.ldCasc) cascCfg <= wrData;
      if (intAck) vecOut <= {base, (intOut ? candPick.idx : {LVL_W{1'b1}})};
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              trigWr,
  input  logic [NUM_IN-1:0] irqIn,
  output logic              intOut,
  input  logic              intAck,
  output logic [DATA_W-1:0] vecOut,
  output logic [DATA_W-1:0] cascCfg
);
  pic_cmd_t cmd;
  phase_t   phase;

  pic_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .trigWr(trigWr), .cmd(cmd), .phaseQ(phase)
  );

  pic_dpath i_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addr(addr), .wrData(wrData),
    .irqIn(irqIn), .intAck(intAck), .intOut(intOut), .rdData(rdData),
    .vecOut(vecOut), .cascCfg(cascCfg)
  );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              addr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic              rdEn,
  input logic              intAck,
  input logic              intOut,
  input logic [DATA_W-1:0] vecOut,
  input logic [NUM_IN-1:0] irrQ,
  input logic [NUM_IN-1:0] isrQ,
  input logic [NUM_IN-1:0] maskQ,
  input phase_t            phase
);
  logic ctlWr;
  assign ctlWr = wrEn & ~addr;

  p_icw1_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData[4]) |=> (isrQ == '0) && (maskQ == '0));

  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && phase == PH_RUN) |=> maskQ == $past(wrData[NUM_IN-1:0]));

  p_int_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irrQ & ~maskQ) != '0));

  p_ack_isr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut && !ctlWr) |=> $countones(isrQ) == $countones($past(isrQ)) + 1);

  p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |=> $stable(vecOut));

  p_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intOut && !ctlWr) |=> (vecOut[LVL_W-1:0] == {LVL_W{1'b1}}) && $stable(isrQ));

  p_eoi_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData == DATA_W'(8'h20) && isrQ != '0 && !intAck && !rdEn)
      |=> $countones(isrQ) == $countones($past(isrQ)) - 1);
endmodule

bind prio_intc prio_intc_chk i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .intAck(intAck), .intOut(intOut), .vecOut(vecOut),
  .irrQ(i_dpath.irr), .isrQ(i_dpath.isr), .maskQ(i_dpath.mask),
  .phase(i_ctrl.phaseQ)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic wrEn = 1'b0, rdEn = 1'b0, trigWr = 1'b0, intAck = 1'b0;
  logic [7:0] irqIn = 8'h00;
  logic [7:0] rdData, vecOut, cascCfg;
  logic intOut;

  always #4 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .trigWr(trigWr), .irqIn(irqIn),
    .intOut(intOut), .intAck(intAck), .vecOut(vecOut), .cascCfg(cascCfg)
  );

  int nChecks = 0, nFail = 0;
  // bench model of the programmer-visible state
  logic [7:0] mIrr = 0, mIsr = 0, mMask = 8'hFF, mTrig = 0, mBase = 0, mVec = 0, mPrev = 0, mCasc = 0;
  int mPhase = 0;
  logic mNeed4 = 0, mLtim = 0, mSel = 0, mPoll = 0;

  function automatic int lowBit(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    int w, iw;
    logic exInt, ackNow, ctlWr, datWr, icw1, lvl;
    logic [7:0] exRd, ackB, eoiB, nIrr;
    #1;
    w = lowBit(mIrr & ~mMask);
    iw = lowBit(mIsr);
    exInt = (w < 8) && (w < iw);
    chk({tag, " intOut"}, {7'd0, intOut}, {7'd0, exInt});
    if (rdEn) begin
      if (addr) exRd = mMask;
      else if (mPoll) exRd = exInt ? {5'b10000, w[2:0]} : 8'h00;
      else exRd = mSel ? mIsr : mIrr;
      chk({tag, " rdData"}, rdData, exRd);
    end
    @(posedge clk);
    ctlWr = wrEn && !addr;
    datWr = wrEn && addr;
    icw1 = ctlWr && wrData[4];
    ackNow = (intAck || (rdEn && !addr && mPoll)) && exInt;
    ackB = ackNow ? (8'd1 << w) : 8'd0;
    eoiB = (ctlWr && !wrData[4] && !wrData[3] && wrData == 8'h20 && iw < 8) ? (8'd1 << iw) : 8'd0;
    for (int i = 0; i < 8; i++) begin
      lvl = mTrig[i] | mLtim;
      nIrr[i] = (lvl ? irqIn[i] : (mIrr[i] | (irqIn[i] & ~mPrev[i]))) & ~ackB[i];
    end
    if (intAck) mVec = {mBase[7:3], exInt ? w[2:0] : 3'd7};
    mIsr = icw1 ? 8'h00 : ((mIsr & ~eoiB) | ackB);
    mIrr = nIrr;
    if (icw1) mMask = 8'h00;
    else if (datWr && mPhase == 0) mMask = wrData;
    if (trigWr) mTrig = wrData;
    if (icw1) begin
      mPhase = 1; mNeed4 = wrData[0]; mLtim = wrData[3]; mSel = 0; mPoll = 0;
    end else begin
      if (datWr) begin
        case (mPhase)
          1: begin mBase = wrData; mPhase = 2; end
          2: begin mCasc = wrData; mPhase = mNeed4 ? 3 : 0; end
          3: mPhase = 0;
          default: mPhase = 0;
        endcase
      end
      if (rdEn && !addr && mPoll) mPoll = 0;
      if (ctlWr && !wrData[4] && wrData[3]) begin
        if (wrData[1]) mSel = wrData[0];
        if (wrData[2]) mPoll = 1;
      end
    end
    mPrev = irqIn;
    @(negedge clk);
    chk({tag, " vecOut"}, vecOut, mVec);
    chk({tag, " cascCfg"}, cascCfg, mCasc);
  endtask

  task automatic wr(logic a, logic [7:0] d, string tag);
    addr = a; wrData = d; wrEn = 1; cyc(tag); wrEn = 0;
  endtask
  task automatic rd(logic a, string tag);
    addr = a; rdEn = 1; cyc(tag); rdEn = 0;
  endtask
  task automatic ack(string tag);
    intAck = 1; cyc(tag); intAck = 0;
  endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask
  task automatic pulse(int b, string tag);
    irqIn[b] = 1; cyc(tag); irqIn[b] = 0; cyc(tag);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(1'b0, "R1 ctl read");
    rd(1'b1, "R1 mask read");
    chk("R1 vec", vecOut, 8'h00);
    // R2 R3 init with mode word
    wr(1'b0, 8'h11, "R2 icw1");
    rd(1'b1, "R2 mask cleared");
    wr(1'b1, 8'h45, "R3 base");
    rd(1'b1, "R3 mask untouched");
    wr(1'b1, 8'h04, "R3 casc");
    wr(1'b1, 8'h01, "R3 mode");
    wr(1'b1, 8'hF0, "R4 mask load");
    rd(1'b1, "R4 mask read");
    // R4 masked request is recorded but silent
    pulse(5, "R4 masked");
    rd(1'b0, "R4 irr shows masked");
    // R5 edge latch and hold
    pulse(3, "R5 edge");
    idle(2, "R5 hold");
    ack("R8 ack lvl3");
    wr(1'b0, 8'h0B, "R11 sel isr");
    rd(1'b0, "R11 isr read");
    // R7 preemption by a higher level, not by a lower one
    pulse(2, "R7 preempt");
    ack("R8 ack lvl2");
    rd(1'b0, "R7 isr nested");
    wr(1'b0, 8'h60, "R10 other ocw2");
    wr(1'b0, 8'h00, "R10 zero ocw2");
    rd(1'b0, "R10 isr unchanged");
    wr(1'b0, 8'h20, "R10 eoi");
    rd(1'b0, "R10 isr after eoi");
    wr(1'b0, 8'h20, "R10 eoi2");
    rd(1'b0, "R10 isr empty");
    // R9 spurious acknowledge
    ack("R9 spurious");
    rd(1'b0, "R9 isr unchanged");
    wr(1'b0, 8'h0A, "R11 sel irr");
    rd(1'b0, "R11 irr read");
    // R6 level input
    wr(1'b1, 8'h00, "R6 unmask");
    trigWr = 1; wrData = 8'h10; cyc("R6 trig"); trigWr = 0;
    irqIn[4] = 1;
    idle(2, "R6 level high");
    rd(1'b0, "R6 irr level");
    ack("R6 ack level");
    idle(2, "R6 still high");
    wr(1'b0, 8'h20, "R6 eoi");
    idle(1, "R6 reassert");
    irqIn[4] = 0;
    idle(2, "R6 level low");
    rd(1'b0, "R6 irr cleared");
    // R12 poll
    pulse(6, "R12 req");
    wr(1'b0, 8'h0C, "R12 arm");
    rd(1'b0, "R12 poll read");
    rd(1'b0, "R12 after poll");
    wr(1'b0, 8'h0B, "R12 sel isr");
    rd(1'b0, "R12 isr after poll");
    wr(1'b0, 8'h0C, "R12 arm empty");
    rd(1'b0, "R12 poll empty");
    // R2 R3 short init, all level
    wr(1'b0, 8'h18, "R2 icw1 level");
    wr(1'b1, 8'h80, "R3 base2");
    wr(1'b1, 8'h02, "R3 casc2");
    wr(1'b1, 8'h3C, "R3 mask after casc");
    rd(1'b1, "R3 mask read");
    irqIn = 8'h81;
    idle(2, "R2 all level");
    ack("R8 vec base2");
    irqIn = 8'h00;
    idle(2, "R2 level drop");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 16;
      if ($urandom % 4 == 0) irqIn[$urandom % 8] ^= 1'b1;
      intAck = ($urandom % 6 == 0);
      if (r < 3) begin addr = 0; wrData = 8'h20; wrEn = 1; end
      else if (r == 3) begin
        addr = 0; wrData = 8'h08 | 8'($urandom % 8); wrEn = 1;
      end else if (r == 4) begin addr = 1; wrData = 8'($urandom); wrEn = 1; end
      else if (r < 8) begin addr = 1'($urandom); rdEn = 1; end
      else if (r == 8 && $urandom % 8 == 0) begin trigWr = 1; wrData = 8'($urandom); end
      else if (r == 9 && $urandom % 20 == 0) begin
        addr = 0; wrData = 8'h10 | 8'($urandom % 2) | (8'($urandom % 2) << 3); wrEn = 1;
      end
      cyc("R7 random");
      wrEn = 0; rdEn = 0; trigWr = 0; intAck = 0;
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule